// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit with Guard Bits

This block multiplies two signed 17-bit operands and folds the product into a 40-bit accumulator. The accumulator can be cleared, loaded with the product, or have the product added or subtracted. The work is split over two registered stages. The first stage forms the product. The second stage combines it with the accumulator. A new operand pair can therefore enter on every clock, and the multiply of one item overlaps the accumulate of the item before it.

The accumulator has a guard field of eight bits on top of a 32-bit result word. The result word is split into a high half and a low half, and each part is a separate output. Two mode bits travel with each operand pair:
- Fractional mode doubles the product before it is used, which removes the extra sign bit of a fractional multiply.
- Saturation mode pins an out-of-range result to the most positive or most negative accumulator value. Without it, the wrapped sum is kept.

An overflow on any item sets a sticky flag. Only a dedicated flag-clear input resets that flag.

Top module: `sat_mac`

## Requirements
- R1: While reset is asserted, and after its release until the first valid item completes, the accumulator reads zero and the overflow flag reads 0.
- R2: An item with op=01 (load) replaces the accumulator with the sign-extended product and discards the previous contents. An item accepted at clock edge k is visible on the outputs after edge k+1.
- R3: op=10 adds the product to the accumulator and op=11 subtracts it. With saturation mode off, the 40-bit result wraps modulo 2^40.
- R4: With frac_en=1, the product is doubled before the load, add or subtract.
- R5: With sat_en=1, a result above 2^39-1 loads 0x7F_FFFF_FFFF and a result below -2^39 loads 0x80_0000_0000. A result of exactly -2^39 is in range and is kept.
- R6: Any item whose result leaves the signed 40-bit range sets ovf_flag, whatever sat_en is. The flag then stays set, and a clear operation does not reset it.
- R7: ovf_clr=1 at an edge resets ovf_flag, unless an overflowing item completes at that same edge, in which case the flag stays 1.
- R8: op=00 (clear) sets the accumulator to zero.
- R9: Items may be presented on consecutive cycles. N items applied back to back produce the final accumulator N+1 edges after the first is presented.
- R10: acc_guard carries accumulator bits 39..32, acc_hi carries bits 31..16 and acc_lo carries bits 15..0.
- R11: Cycles with in_valid=0 leave the accumulator and the flag unchanged, whatever op, operands and modes are driven.
- R12: Summing 256 products of two operands in the 16-bit signed range never sets the overflow flag. With both operands at -32768, the total is 2^38.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies op, operands and modes for this cycle |
| op | input | 2 | 00 clear, 01 load product, 10 add, 11 subtract |
| frac_en | input | 1 | Double the product |
| sat_en | input | 1 | Saturate out-of-range results |
| mul_a | input | 17 | Signed multiplicand |
| mul_b | input | 17 | Signed multiplier |
| ovf_clr | input | 1 | Reset the sticky overflow flag |
| acc_guard | output | 8 | Accumulator bits 39..32 |
| acc_hi | output | 16 | Accumulator bits 31..16 |
| acc_lo | output | 16 | Accumulator bits 15..0 |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The bench walks the accumulator in doubled full-scale steps, first to just below the positive limit and then across it.
- Without saturation, this shows whether the design wraps to the most negative value. A design that saturated anyway, or lost the carry into the guard field, would miscompare there.
- With saturation, it shows whether the result pins to the maximum. A subtract run stops exactly on -2^39, which catches an off-by-one range test that would flag or pin a legal value.

Further checks target specific faults:
- Asserting the flag clear on the same edge as an overflow catches a clear that wins over the set.
- A 256-term run of extreme 16-bit products checks the cycle count and catches a missing guard bit.
- Random mixed traffic compares every item against a reference model, which catches a wrong sign extension of negative products.

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int OPW    = 17,
  parameter int ACCW   = 40,
  parameter int GUARDW = 8,
  parameter int SATW   = ACCW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              frac_en,
  input  logic              sat_en,
  input  logic [OPW-1:0]    mul_a,
  input  logic [OPW-1:0]    mul_b,
  input  logic              ovf_clr,
  output logic [GUARDW-1:0] acc_guard,
  output logic [(ACCW-GUARDW)/2-1:0] acc_hi,
  output logic [(ACCW-GUARDW)/2-1:0] acc_lo,
  output logic              ovf_flag
);
  localparam int HALFW = (ACCW - GUARDW) / 2;
  localparam int PRODW = 2 * OPW;
  localparam int SUMW  = ACCW + 1;
  localparam int TOPW  = SUMW - SATW + 1;
  localparam logic [1:0] OP_CLR = 2'b00, OP_LOAD = 2'b01, OP_ADD = 2'b10, OP_SUB = 2'b11;
  localparam logic [ACCW-1:0] SAT_MAX = {{(ACCW-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
  localparam logic [ACCW-1:0] SAT_MIN = ~SAT_MAX;

  // stage 1: product
  logic             s1_valid, s1_frac, s1_sat;
  logic [1:0]       s1_op;
  logic [PRODW-1:0] s1_prod;
  logic [PRODW-1:0] a_ext, b_ext;

  assign a_ext = {{OPW{mul_a[OPW-1]}}, mul_a};
  assign b_ext = {{OPW{mul_b[OPW-1]}}, mul_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_CLR;
      s1_frac  <= 1'b0;
      s1_sat   <= 1'b0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op   <= op;
        s1_frac <= frac_en;
        s1_sat  <= sat_en;
        s1_prod <= a_ext * b_ext;
      end
    end
  end

  // stage 2: accumulate
  logic [ACCW-1:0] acc;
  logic [SUMW-1:0] prod_ext, scaled, acc_ext, sum;
  logic [TOPW-1:0] top;
  logic            ovf_now;

  assign prod_ext = {{(SUMW-PRODW){s1_prod[PRODW-1]}}, s1_prod};
  assign scaled   = s1_frac ? {prod_ext[SUMW-2:0], 1'b0} : prod_ext;
  assign acc_ext  = {acc[ACCW-1], acc};

  always_comb begin
    case (s1_op)
      OP_LOAD: sum = scaled;
      OP_ADD:  sum = acc_ext + scaled;
      OP_SUB:  sum = acc_ext - scaled;
      default: sum = '0;
    endcase
  end

  assign top     = sum[SUMW-1:SATW-1];
  assign ovf_now = s1_valid && (top != '0) && (top != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (s1_valid) begin
      if (ovf_now && s1_sat) acc <= sum[SUMW-1] ? SAT_MIN : SAT_MAX;
      else                   acc <= sum[ACCW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_now) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign acc_guard = acc[ACCW-1 -: GUARDW];
  assign acc_hi    = acc[2*HALFW-1 -: HALFW];
  assign acc_lo    = acc[HALFW-1:0];

  p_sat_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_now && s1_sat) |=> (acc == SAT_MAX || acc == SAT_MIN));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> ovf_flag);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_now) |=> !ovf_flag);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OP_CLR) |=> (acc == '0));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(acc));
endmodule

// File: tb/test_sat_mac.sv
module test_sat_mac;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXV = (64'sd1 <<< 39) - 1;
  localparam longint MINV = -(64'sd1 <<< 39);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, frac_en = 1'b0, sat_en = 1'b0, ovf_clr = 1'b0;
  logic [1:0] op = 2'b00;
  logic [16:0] mul_a = '0, mul_b = '0;
  logic [7:0] acc_guard;
  logic [15:0] acc_hi, acc_lo;
  logic ovf_flag;

  sat_mac i_sat_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .frac_en(frac_en),
    .sat_en(sat_en), .mul_a(mul_a), .mul_b(mul_b), .ovf_clr(ovf_clr),
    .acc_guard(acc_guard), .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf_flag(ovf_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [39:0] acc; logic flag; int req; } exp_t;
  exp_t sbq[$];
  int checks = 0, fails = 0;
  longint cyc = 0;
  logic [1:0] vpipe = 2'b00;
  longint m_acc = 0;
  bit m_flag = 0;
  wire [39:0] acc_all = {acc_guard, acc_hi, acc_lo};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    vpipe <= rst_n ? {vpipe[0], in_valid} : 2'b00;
  end

  always @(negedge clk) begin
    if (vpipe[1]) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL R9: result appeared with nothing expected (acc=%h)", acc_all);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (acc_all !== e.acc || ovf_flag !== e.flag) begin
          fails++;
          $display("FAIL R%0d: acc=%h flag=%b expected acc=%h flag=%b",
                   e.req, acc_all, ovf_flag, e.acc, e.flag);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [16:0] v);
    return v[16] ? longint'(v) - 131072 : longint'(v);
  endfunction

  task automatic issue(input logic [1:0] o, input logic [16:0] a, input logic [16:0] b,
                       input bit fr, input bit st, input int req);
    longint p, s;
    bit ov;
    exp_t e;
    p = sx(a) * sx(b);
    if (fr) p = p * 2;
    case (o)
      2'b00: s = 0;
      2'b01: s = p;
      2'b10: s = m_acc + p;
      default: s = m_acc - p;
    endcase
    ov = (s > MAXV) || (s < MINV);
    if (ov && st) m_acc = (s > 0) ? MAXV : MINV;
    else if (ov) begin
      m_acc = s & ((64'sd1 <<< 40) - 1);
      if (m_acc[39]) m_acc = m_acc - (64'sd1 <<< 40);
    end else m_acc = s;
    if (ov) m_flag = 1;
    e.acc = m_acc[39:0]; e.flag = m_flag; e.req = req;
    sbq.push_back(e);
    in_valid = 1'b1; op = o; mul_a = a; mul_b = b; frac_en = fr; sat_en = st;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; op = 2'($urandom); mul_a = 17'($urandom); mul_b = 17'($urandom);
      frac_en = 1'($urandom); sat_en = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    idle(2);
    ovf_clr = 1'b1; idle(1); ovf_clr = 1'b0;
    m_flag = 0;
    chk(ovf_flag == 1'b0, "R7 clear", 64'(ovf_flag), 64'd0);
  endtask

  localparam logic [16:0] NEG_FULL = 17'h10000; // -65536
  localparam logic [16:0] NEG_HALF = 17'h18000; // -32768

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    longint c0;
    logic [39:0] held;
    logic hflag;
    repeat (3) @(negedge clk);
    chk(acc_all == 40'd0 && ovf_flag == 1'b0, "R1 in reset", {23'd0, ovf_flag, acc_all}, 64'd0);
    rst_n = 1'b1;
    idle(2);
    chk(acc_all == 40'd0 && ovf_flag == 1'b0, "R1 after reset", {23'd0, ovf_flag, acc_all}, 64'd0);

    // R2 load and discard
    issue(2'b10, 17'd100, 17'd7, 0, 0, 3);
    issue(2'b01, 17'd123, -17'sd45, 0, 0, 2);
    issue(2'b01, -17'sd3, 17'd5, 0, 0, 2);
    idle(2);
    // R10 field split of -15
    chk(acc_guard == 8'hFF && acc_hi == 16'hFFFF && acc_lo == 16'hFFF1, "R10 negative fields",
        64'(acc_all), 64'hFF_FFFF_FFF1);
    // R4 doubled extreme product = 2^33
    issue(2'b01, NEG_FULL, NEG_FULL, 1, 0, 4);
    idle(2);
    chk(acc_guard == 8'h02 && acc_hi == 16'h0 && acc_lo == 16'h0, "R10 guard field",
        64'(acc_all), 64'h02_0000_0000);
    issue(2'b10, 17'd3, 17'd4, 1, 0, 4);
    issue(2'b11, -17'sd7, 17'd9, 1, 1, 4);

    // R3 random add/sub/load/clear traffic, back to back
    for (int i = 0; i < 300; i++) begin
      logic [1:0] o;
      o = 2'($urandom);
      if (o == 2'b00 && ($urandom % 4) != 0) o = 2'b10;
      issue(o, 17'($urandom), 17'($urandom), 1'($urandom), 1'($urandom), 3);
      if ($urandom % 8 == 0) idle(1);
    end
    idle(2);
    clear_flag();

    // R6 wrap without saturation: 63 * 2^33 then one more step
    issue(2'b01, NEG_FULL, NEG_FULL, 1, 0, 6);
    for (int i = 0; i < 62; i++) issue(2'b10, NEG_FULL, NEG_FULL, 1, 0, 6);
    idle(2);
    chk(acc_all == 40'h7E_0000_0000 && !ovf_flag, "R6 below limit", 64'(acc_all), 64'h7E_0000_0000);
    issue(2'b10, NEG_FULL, NEG_FULL, 1, 0, 3);
    idle(2);
    chk(acc_all == 40'h80_0000_0000 && ovf_flag, "R3 wrap to most negative", 64'(acc_all), 64'h80_0000_0000);
    // R8 clear op keeps the sticky flag
    issue(2'b00, 17'd1, 17'd1, 0, 0, 8);
    idle(2);
    chk(acc_all == 40'd0 && ovf_flag == 1'b1, "R8 clear keeps flag", {23'd0, ovf_flag, acc_all}, 64'h1_00_0000_0000);
    clear_flag();

    // R5 positive saturation
    issue(2'b01, NEG_FULL, NEG_FULL, 1, 1, 5);
    for (int i = 0; i < 63; i++) issue(2'b10, NEG_FULL, NEG_FULL, 1, 1, 5);
    idle(2);
    chk(acc_all == 40'h7F_FFFF_FFFF && ovf_flag, "R5 pin to max", 64'(acc_all), 64'h7F_FFFF_FFFF);
    clear_flag();

    // R5 negative: exactly -2^39 is legal, one more step pins
    issue(2'b00, 17'd0, 17'd0, 0, 1, 8);
    for (int i = 0; i < 64; i++) issue(2'b11, NEG_FULL, NEG_FULL, 1, 1, 5);
    idle(2);
    chk(acc_all == 40'h80_0000_0000 && !ovf_flag, "R5 exact minimum kept", 64'(acc_all), 64'h80_0000_0000);
    issue(2'b11, NEG_FULL, NEG_FULL, 1, 1, 5);
    // R7 clear on the same edge the overflow completes: set wins
    ovf_clr = 1'b1;
    idle(1);
    chk(ovf_flag == 1'b1 && acc_all == 40'h80_0000_0000, "R7 set wins over clear",
        64'(ovf_flag), 64'd1);
    idle(1);
    ovf_clr = 1'b0;
    m_flag = 0;
    chk(ovf_flag == 1'b0, "R7 clear next edge", 64'(ovf_flag), 64'd0);

    // R11 idle cycles change nothing
    issue(2'b01, 17'd321, -17'sd99, 0, 0, 2);
    idle(2);
    held = acc_all; hflag = ovf_flag;
    for (int i = 0; i < 6; i++) begin
      idle(1);
      chk(acc_all == held && ovf_flag == hflag, "R11 idle hold", 64'(acc_all), 64'(held));
    end

    // R12 + R9: 256 extreme 16-bit products, timed
    issue(2'b00, 17'd0, 17'd0, 0, 0, 8);
    idle(2);
    c0 = cyc;
    for (int i = 0; i < 256; i++) issue(2'b10, NEG_HALF, NEG_HALF, 0, 0, 12);
    idle(1);
    chk(cyc - c0 == 257, "R9 N+1 cycles", 64'(cyc - c0), 64'd257);
    chk(acc_all == 40'h40_0000_0000 && !ovf_flag, "R12 no overflow at 256 terms",
        {23'd0, ovf_flag, acc_all}, 64'h40_0000_0000);

    idle(3);
    chk(sbq.size() == 0, "R9 all results seen", 64'(sbq.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule